// File: doc/BRIEF.md
# SMBus Alert Responder

This block sits on the target side of an SMBus segment and raises an open-drain alert when an enabled monitoring event is pending. Status bits arrive in three categories (temperature, voltage and fan), and each category has its own gate enable. The alert is armed by an interrupt-enable bit that the block owns. Software sets and clears that bit. A new alert is raised only on a monitoring-cycle strobe.

When the host reads from the SMBus Alert Response Address (7'b0001100, read direction), the block acknowledges only if it is the device calling for service. It then returns its 7-bit device address in the upper bits of the data byte. On that acknowledge, the block clears its own interrupt-enable bit, which drops the alert. The status bits are left unchanged. A condition that persists raises the alert again only after software restores the enable, and only at the next monitoring strobe.

A strap input selects a variant without an alert pin. In that variant the alert output stays released. The block then answers the Alert Response Address whenever the enable bit is set and an enabled status bit is active, with no monitoring strobe needed.

Top module: `smb_alert_resp`

## Requirements
- R1: `alert_o` (1 = pull the line low) is asserted only while `int_en_o` is 1 and at least one status bit is set in a category whose enable input is 1.
- R2: `alert_o` rises only in the cycle after a `mon_tick_i` pulse. It falls within two cycles of the enable bit being cleared or of the enabled status going away.
- R3: A read from address 7'b0001100 (R/W bit = 1) that the block accepts is acknowledged by pulling SDA low during the ninth clock. It is followed by the byte {dev_addr_i, 1'b0}, sent MSB first.
- R4: With `nopin_i` = 0, the block acknowledges the Alert Response Address only while its alert is asserted.
- R5: Acknowledging the Alert Response Address clears `int_en_o`, and `alert_o` is released as a result. The status inputs are not consumed.
- R6: After such a clear, a persisting condition does not re-raise the alert on later strobes until software writes the enable bit to 1. After that write, the next `mon_tick_i` re-raises it.
- R7: With `nopin_i` = 1, `alert_o` is never asserted. The block answers the Alert Response Address only when `int_en_o` is 1 and an enabled status bit is set, regardless of strobes.
- R8: Any other address, or the write direction, leaves SDA untouched for the whole transaction, and the block returns to idle.
- R9: `sda_pd_o` changes only while SCL is low.
- R10: A low pulse of one clock cycle on SCL is filtered out and does not disturb bit counting.
- R11: A pulse on `ien_we_i` loads `ien_wd_i` into the enable bit on the next clock edge.
- R12: After reset, `alert_o`, `sda_pd_o` and `int_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line sample |
| sda_i | input | 1 | SDA line sample |
| sda_pd_o | output | 1 | 1 = pull SDA low |
| alert_o | output | 1 | 1 = pull the alert line low |
| stat_temp_i | input | N_TEMP | Temperature status bits |
| stat_volt_i | input | N_VOLT | Voltage status bits |
| stat_fan_i | input | N_FAN | Fan status bits |
| en_temp_i | input | 1 | Gate temperature status onto the alert |
| en_volt_i | input | 1 | Gate voltage status onto the alert |
| en_fan_i | input | 1 | Gate fan status onto the alert |
| ien_we_i | input | 1 | Software write strobe for the interrupt-enable bit |
| ien_wd_i | input | 1 | Value written to the interrupt-enable bit |
| int_en_o | output | 1 | Current interrupt-enable bit |
| mon_tick_i | input | 1 | Monitoring-cycle strobe |
| dev_addr_i | input | 7 | Own device address returned on an alert response |
| nopin_i | input | 1 | Strap: 1 selects the variant without an alert pin |

## Verification
Assertions check these on every cycle:
- a new alert appears only after a strobe;
- an asserted alert follows from an armed, enabled source;
- an acknowledge always clears the enable bit and is always preceded by a willingness to respond;
- SDA is never held in idle or address states, and it changes only while filtered SCL is low.

Other behaviour can only be shown by bus scenarios:
- the returned byte value;
- refusal on a foreign address or the write direction;
- the strap variant's strobe-free answer;
- the re-arm sequence after a clear;
- immunity to a one-cycle SCL glitch.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK
  } ara_state_e;

  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic hist_q, filt_q, prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= line_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  endgenerate

  // accept a level only after two equal samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b1;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      hist_q <= sync_q[SYNC_STAGES-1];
      if (sync_q[SYNC_STAGES-1] == hist_q) filt_q <= hist_q;
      prev_q <= filt_q;
    end
  end

  assign line_o = filt_q;
  assign rise_o = filt_q & ~prev_q;
  assign fall_o = ~filt_q & prev_q;

  a_r10_no_single_cycle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rise_o) |=> !rise_o);
endmodule

// File: rtl/smb_alert_gate.sv
module smb_alert_gate #(
  parameter int unsigned N_TEMP = 2,
  parameter int unsigned N_VOLT = 4,
  parameter int unsigned N_FAN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TEMP-1:0] stat_temp_i,
  input  logic [N_VOLT-1:0] stat_volt_i,
  input  logic [N_FAN-1:0]  stat_fan_i,
  input  logic              en_temp_i,
  input  logic              en_volt_i,
  input  logic              en_fan_i,
  input  logic              ien_we_i,
  input  logic              ien_wd_i,
  input  logic              ara_ack_i,
  input  logic              mon_tick_i,
  input  logic              nopin_i,
  output logic              int_en_o,
  output logic              alert_o,
  output logic              respond_o
);
  logic pending, int_en_q, alert_q;

  assign pending = (|stat_temp_i & en_temp_i) |
                   (|stat_volt_i & en_volt_i) |
                   (|stat_fan_i  & en_fan_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= 1'b0;
      alert_q  <= 1'b0;
    end else begin
      if (ara_ack_i)     int_en_q <= 1'b0;
      else if (ien_we_i) int_en_q <= ien_wd_i;
      // new alerts only on a monitoring strobe; an existing one holds while armed
      alert_q <= int_en_q & pending & (alert_q | mon_tick_i);
    end
  end

  assign int_en_o  = int_en_q;
  assign alert_o   = alert_q & ~nopin_i;
  assign respond_o = nopin_i ? (int_en_q & pending) : alert_q;

  a_r2_raise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_q) |-> $past(mon_tick_i));
  a_r1_alert_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_q |-> $past(pending & int_en_q));
  a_r5_ack_clears_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_ack_i |=> !int_en_q);
  a_r6_no_alert_on_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_en_q) |-> !alert_q);
endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import smb_alert_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_f_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_f_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  input  logic [6:0] dev_addr_i,
  input  logic       respond_i,
  output logic       sda_pd_o,
  output logic       ack_o
);
  ara_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q, tx_q;
  logic       pd_q, ack_q;
  logic       start_c, stop_c, hit_c;

  assign start_c = scl_f_i & sda_fall_i;
  assign stop_c  = scl_f_i & sda_rise_i;
  assign hit_c   = (shreg_q[7:1] == ARA_ADDR) & shreg_q[0] & respond_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      pd_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (start_c) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pd_q    <= 1'b0;
      end else if (stop_c) begin
        state_q <= ST_IDLE;
        pd_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[6:0], sda_f_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'(BYTE_BITS)) begin
              if (hit_c) begin
                state_q <= ST_AACK;
                pd_q    <= 1'b1;
                ack_q   <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              state_q <= ST_DATA;
              tx_q    <= {dev_addr_i, 1'b0};
              pd_q    <= ~dev_addr_i[6];
              cnt_q   <= '0;
            end
          end
          ST_DATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'(BYTE_BITS)) begin
                pd_q    <= 1'b0;
                state_q <= ST_DACK;
              end else begin
                pd_q <= ~tx_q[6];
                tx_q <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_DACK: if (scl_rise_i) state_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign sda_pd_o = pd_q;
  assign ack_o    = ack_q;

  a_r9_pd_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_q) |-> !scl_f_i);
  a_r4_ack_needs_respond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(respond_i));
  a_r3_ack_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK) |-> pd_q);
  a_r8_released_in_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_ADDR) |-> !pd_q);
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter int unsigned N_TEMP      = 2,
  parameter int unsigned N_VOLT      = 4,
  parameter int unsigned N_FAN       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  output logic              alert_o,
  input  logic [N_TEMP-1:0] stat_temp_i,
  input  logic [N_VOLT-1:0] stat_volt_i,
  input  logic [N_FAN-1:0]  stat_fan_i,
  input  logic              en_temp_i,
  input  logic              en_volt_i,
  input  logic              en_fan_i,
  input  logic              ien_we_i,
  input  logic              ien_wd_i,
  output logic              int_en_o,
  input  logic              mon_tick_i,
  input  logic [6:0]        dev_addr_i,
  input  logic              nopin_i
);
  logic scl_f, scl_rise, scl_fall;
  logic sda_f, sda_rise, sda_fall;
  logic respond, ara_ack;

  smb_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_scl (
    .clk_i, .rst_ni, .line_i(scl_i),
    .line_o(scl_f), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  smb_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_sda (
    .clk_i, .rst_ni, .line_i(sda_i),
    .line_o(sda_f), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  smb_alert_gate #(.N_TEMP(N_TEMP), .N_VOLT(N_VOLT), .N_FAN(N_FAN)) u_gate (
    .clk_i, .rst_ni,
    .stat_temp_i, .stat_volt_i, .stat_fan_i,
    .en_temp_i, .en_volt_i, .en_fan_i,
    .ien_we_i, .ien_wd_i,
    .ara_ack_i(ara_ack),
    .mon_tick_i, .nopin_i,
    .int_en_o, .alert_o,
    .respond_o(respond)
  );

  smb_ara_fsm u_fsm (
    .clk_i, .rst_ni,
    .scl_f_i(scl_f), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_f_i(sda_f), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .dev_addr_i,
    .respond_i(respond),
    .sda_pd_o,
    .ack_o(ara_ack)
  );

  a_r7_strap_keeps_pin_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nopin_i && $past(nopin_i)) |-> !alert_o);
endmodule

// File: tb/sim_smb_alert_resp.sv
module sim_smb_alert_resp;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 16;
  localparam logic [6:0] ARA = 7'h0C;

  typedef struct packed {
    logic [6:0] addr;
    logic       rw;
    logic [1:0] st_t;
    logic [3:0] st_v;
    logic [1:0] st_f;
    logic [2:0] en;
    logic       ien;
    logic       nopin;
    logic       tick;
    logic       exp_alert;
    logic       exp_ack;
    logic       exp_after;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{7'h0C, 1'b1, 2'b01, 4'b0000, 2'b00, 3'b100, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{7'h0C, 1'b1, 2'b00, 4'b0100, 2'b00, 3'b101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{7'h0C, 1'b0, 2'b00, 4'b0000, 2'b10, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{7'h2C, 1'b1, 2'b00, 4'b0000, 2'b10, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{7'h0C, 1'b1, 2'b10, 4'b0000, 2'b00, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{7'h0C, 1'b1, 2'b00, 4'b1000, 2'b00, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{7'h0C, 1'b1, 2'b00, 4'b1000, 2'b00, 3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'h0C, 1'b1, 2'b01, 4'b0000, 2'b00, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{7'h0C, 1'b1, 2'b00, 4'b0000, 2'b01, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_h = 1'b1;
  logic sda_pd, alert, int_en;
  logic [1:0] st_t = '0;
  logic [3:0] st_v = '0;
  logic [1:0] st_f = '0;
  logic en_t = 1'b0, en_v = 1'b0, en_f = 1'b0;
  logic we = 1'b0, wd = 1'b0, tick = 1'b0, nopin = 1'b0;
  logic [6:0] dev = 7'h2D;
  logic sda_w;
  int checks = 0, fails = 0, r9_bad = 0;
  logic pd_seen = 1'b0, pd_last = 1'b0;

  assign sda_w = sda_h & ~sda_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_alert_resp u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .scl_i(scl_drv), .sda_i(sda_w),
    .sda_pd_o(sda_pd), .alert_o(alert),
    .stat_temp_i(st_t), .stat_volt_i(st_v), .stat_fan_i(st_f),
    .en_temp_i(en_t), .en_volt_i(en_v), .en_fan_i(en_f),
    .ien_we_i(we), .ien_wd_i(wd), .int_en_o(int_en),
    .mon_tick_i(tick), .dev_addr_i(dev), .nopin_i(nopin)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance n cycles, watching SDA drive for R9 and R8
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sda_pd) pd_seen = 1'b1;
      if (sda_pd != pd_last && scl_drv) r9_bad++;
      pd_last = sda_pd;
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(1); tick = 1'b0; step(1);
  endtask

  task automatic wr_ien(input logic v);
    we = 1'b1; wd = v; step(1); we = 1'b0; step(1);
  endtask

  task automatic txn(input logic [6:0] a, input logic rw, input bit glitch,
                     output logic ack, output logic [7:0] rd);
    logic [7:0] ab;
    ab = {a, rw};
    rd = '0;
    sda_h = 1'b1; scl_drv = 1'b1; step(HP);
    sda_h = 1'b0; step(HP);
    scl_drv = 1'b0; step(4);
    for (int i = 7; i >= 0; i--) begin
      sda_h = ab[i]; step(HP);
      scl_drv = 1'b1;
      if (glitch && i == 4) begin
        step(HP/2); scl_drv = 1'b0; step(1); scl_drv = 1'b1; step(HP/2 - 1);
      end else begin
        step(HP);
      end
      scl_drv = 1'b0; step(4);
    end
    sda_h = 1'b1; step(HP);
    scl_drv = 1'b1; step(HP/2); ack = ~sda_w; step(HP/2);
    scl_drv = 1'b0; step(4);
    for (int i = 0; i < 8; i++) begin
      step(HP);
      scl_drv = 1'b1; step(HP/2); rd = {rd[6:0], sda_w}; step(HP/2);
      scl_drv = 1'b0; step(4);
    end
    sda_h = 1'b1; step(HP);
    scl_drv = 1'b1; step(HP); scl_drv = 1'b0; step(4);
    sda_h = 1'b0; step(HP);
    scl_drv = 1'b1; step(HP);
    sda_h = 1'b1; step(HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    step(3);
    rst_n = 1'b1;
    step(3);
    // R12 reset state
    chk(alert == 1'b0, "R12 alert", alert, 0);
    chk(sda_pd == 1'b0, "R12 sda", sda_pd, 0);
    chk(int_en == 1'b0, "R12 int_en", int_en, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      st_t = VECS[v].st_t; st_v = VECS[v].st_v; st_f = VECS[v].st_f;
      {en_t, en_v, en_f} = VECS[v].en;
      nopin = VECS[v].nopin;
      wr_ien(VECS[v].ien);
      chk(int_en == VECS[v].ien, "R11 write", int_en, VECS[v].ien);
      if (VECS[v].tick) pulse_tick();
      step(3);
      chk(alert == VECS[v].exp_alert, VECS[v].nopin ? "R7 alert" : "R1 alert", alert, VECS[v].exp_alert);
      tag = VECS[v].nopin ? "R7 ack" : ((VECS[v].addr != ARA || !VECS[v].rw) ? "R8 ack" : "R4 ack");
      pd_seen = 1'b0;
      txn(VECS[v].addr, VECS[v].rw, 1'b0, ack, rd);
      chk(ack == VECS[v].exp_ack, tag, ack, VECS[v].exp_ack);
      if (VECS[v].exp_ack) chk(rd == {dev, 1'b0}, "R3 byte", rd, {dev, 1'b0});
      else                 chk(pd_seen == 1'b0, "R8 untouched", pd_seen, 0);
      step(3);
      chk(int_en == (VECS[v].exp_ack ? 1'b0 : VECS[v].ien), "R5 int_en", int_en,
          VECS[v].exp_ack ? 1'b0 : VECS[v].ien);
      chk(alert == VECS[v].exp_after, "R5 alert after", alert, VECS[v].exp_after);
    end

    // R6 re-arm sequence with a different own address
    nopin = 1'b0; dev = 7'h41;
    st_t = 2'b10; st_v = '0; st_f = '0; en_t = 1'b1; en_v = 1'b0; en_f = 1'b0;
    wr_ien(1'b1); pulse_tick(); step(2);
    chk(alert == 1'b1, "R1 raised", alert, 1);
    txn(ARA, 1'b1, 1'b0, ack, rd);
    chk(ack == 1'b1 && rd == 8'h82, "R3 byte 0x82", {ack, rd}, {1'b1, 8'h82});
    step(2);
    chk(alert == 1'b0, "R5 released", alert, 0);
    pulse_tick(); step(2);
    chk(alert == 1'b0, "R6 no rearm on tick", alert, 0);
    wr_ien(1'b1); step(3);
    chk(alert == 1'b0, "R2 no tick yet", alert, 0);
    pulse_tick(); step(1);
    chk(alert == 1'b1, "R6 rearmed", alert, 1);

    // R10 glitch on SCL during address phase
    txn(ARA, 1'b1, 1'b1, ack, rd);
    chk(ack == 1'b1 && rd == 8'h82, "R10 glitch", {ack, rd}, {1'b1, 8'h82});

    // R2 fall on enable clear and on status removal
    wr_ien(1'b1); pulse_tick(); step(1);
    chk(alert == 1'b1, "R2 raise", alert, 1);
    wr_ien(1'b0); step(1);
    chk(alert == 1'b0, "R2 fall on clear", alert, 0);
    wr_ien(1'b1); pulse_tick(); step(1);
    st_t = '0; step(2);
    chk(alert == 1'b0, "R2 fall on status", alert, 0);

    chk(r9_bad == 0, "R9 sda moved with scl high", r9_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule